// File: doc/BRIEF.md
# Buffered Dual-Register PWM Generator

This block is a timer with two PWM channels that share one counter. The counter runs from zero up to a programmable modulo value and then wraps. It advances only on cycles where the external prescaler tick is high and the timer is not stopped. Each channel has a compare register and a control register. In unbuffered mode a channel's own compare register sets its pulse width directly.

In buffered mode, channel 0 links the two compare registers and uses them to drive the channel 0 output alone. One register is active and the other is a staging slot. Software writes the next width into the staging register. The swap happens at the next counter wrap, so a width change never glitches mid-period. While the pair is linked, the second output is held low and a flag tells the pad logic that the pin is free for general-purpose use.

All configuration arrives through a single write port of address, data and enable. The current counter value is also brought out.

Top module: `bpwm_pair`

## Requirements
- R1: After reset the counter is 0, the modulo register is all ones, both outputs are low and the pin-free flag is low. On each advancing cycle the counter steps by one, and when it equals the modulo value it wraps to 0.
- R2: The counter and both channel outputs hold their values on any cycle where the tick input is low or the stop bit (timer control, address 5, data bit 0) is set.
- R3: Writing timer control with data bit 1 set clears the counter to 0 at that clock edge. The bit does not persist: counting resumes on the next advancing cycle.
- R4: Control bits [1:0] select the channel mode: 01 is unbuffered PWM, and 10 on channel 0 is buffered PWM. Any other value holds that channel's output low. Addresses: 0 modulo, 1 compare 0, 2 compare 1, 3 control 0, 4 control 1.
- R5: Control bits [3:2] select the output action. 10 drives the output low on a compare match and 11 drives it high. With 0x there is no action and the output holds its level. When bit 4 is set, a counter wrap drives the output to the opposite of the compare level.
- R6: With compare value C not above modulo M and the clear-on-match action, the output is high for C of every M+1 advancing cycles. With the set-on-match action it is high for M+1-C cycles.
- R7: A compare value above the modulo never matches, so the output stays at the wrap level (100% or 0%). A compare value of 0 matches on the wrap cycle and wins over the wrap action, so the output stays at the compare level.
- R8: On entering buffered mode, compare register 0 is the active width source, whatever was written to compare register 1 before.
- R9: In buffered mode, a write to the inactive compare register does not affect the current period. That register becomes active at the next counter wrap.
- R10: At each wrap in buffered mode, the active register is the one of the pair written most recently. A write to the active register after a write to the inactive one cancels the pending swap.
- R11: In buffered mode, a write to the active compare register changes the width within the current period.
- R12: While buffered mode is selected, the pin-free flag is high, the channel 1 output is low, and channel 1's control register has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Write data |
| tick_i | input | 1 | Prescaler tick enable |
| cnt_o | output | CNT_W | Current counter value |
| ch0_pwm_o | output | 1 | Channel 0 (or linked pair) PWM output |
| ch1_pwm_o | output | 1 | Channel 1 PWM output |
| ch1_free_o | output | 1 | Channel 1 pin released for general use |

## Verification
On every cycle the assertions check the following:
- The counter wraps and holds correctly, including when the timer is stopped or cleared.
- The active selection changes only at a wrap, and the pending flag clears after a wrap that has no write.
- Each output follows its compare and wrap actions and stays frozen on idle cycles.

The bench scenarios show the duty-cycle arithmetic across several modulo, compare and polarity combinations, including the 0% and 100% corners. The buffered-mode ordering is shown only by sampling the output at chosen counter phases: a deferred swap, an immediate change to the active register, and the last write winning.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  localparam int CTL_W = 5;

  typedef enum logic [2:0] {
    A_MOD  = 3'd0,
    A_CMP0 = 3'd1,
    A_CMP1 = 3'd2,
    A_CTL0 = 3'd3,
    A_CTL1 = 3'd4,
    A_TMR  = 3'd5
  } addr_e;

  typedef struct packed {
    logic       tov;
    logic [1:0] edge_sel;
    logic [1:0] mode;
  } ch_ctl_t;

  localparam logic [1:0] MODE_UNBUF = 2'b01;
  localparam logic [1:0] MODE_BUF   = 2'b10;
endpackage

// File: rtl/bpwm_counter.sv
module bpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             adv_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign adv_o     = tick_i & ~stop_i & ~clr_i;
  assign wrap_o    = adv_o & (cnt_q == mod_i);
  assign cnt_nxt_o = wrap_o ? '0 : cnt_q + CNT_W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_o) cnt_q <= cnt_nxt_o;
  end

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/bpwm_sel.sv
module bpwm_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic buf_en_i,
  input  logic wrap_i,
  input  logic wr_cmp0_i,
  input  logic wr_cmp1_i,
  output logic act_nxt_o
);
  logic act_q, pend_q;

  // selection in force for the compare made on this cycle
  assign act_nxt_o = (wrap_i & pend_q) ? ~act_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (!buf_en_i) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      act_q <= act_nxt_o;
      if (wr_cmp1_i)      pend_q <= ~act_nxt_o;
      else if (wr_cmp0_i) pend_q <= act_nxt_o;
      else if (wrap_i)    pend_q <= 1'b0;
    end
  end

  p_swap_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_i && !wrap_i) |=> ($stable(act_q) || !buf_en_i));
  p_pend_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_i && wrap_i && !wr_cmp0_i && !wr_cmp1_i) |=> !pend_q);
  p_enter_ch0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_en_i |=> (!act_q && !pend_q));
endmodule

// File: rtl/bpwm_out.sv
module bpwm_out import bpwm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  ch_ctl_t          ctl_i,
  output logic             out_o
);
  logic out_q, hit;

  assign hit   = (cnt_nxt_i == cmp_i);
  assign out_o = out_q;

  // compare action wins over wrap action
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else if (adv_i && ctl_i.edge_sel[1]) begin
      if (hit)                    out_q <= ctl_i.edge_sel[0];
      else if (wrap_i && ctl_i.tov) out_q <= ~ctl_i.edge_sel[0];
    end
  end

  p_cmp_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && hit && ctl_i.edge_sel[1]) |=> (out_q == $past(ctl_i.edge_sel[0])));
  p_wrap_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i && !hit && ctl_i.tov && ctl_i.edge_sel[1])
      |=> (out_q != $past(ctl_i.edge_sel[0])));
  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(out_q));
endmodule

// File: rtl/bpwm_pair.sv
module bpwm_pair import bpwm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ch0_pwm_o,
  output logic             ch1_pwm_o,
  output logic             ch1_free_o
);
  localparam int N_CH = 2;

  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] cmp_q [N_CH];
  ch_ctl_t          ctl_q [N_CH];
  logic             stop_q;

  logic wr_mod, wr_tmr, clr;
  logic [N_CH-1:0] wr_cmp, wr_ctl;

  assign wr_mod    = wr_en_i && (wr_addr_i == A_MOD);
  assign wr_tmr    = wr_en_i && (wr_addr_i == A_TMR);
  assign wr_cmp[0] = wr_en_i && (wr_addr_i == A_CMP0);
  assign wr_cmp[1] = wr_en_i && (wr_addr_i == A_CMP1);
  assign wr_ctl[0] = wr_en_i && (wr_addr_i == A_CTL0);
  assign wr_ctl[1] = wr_en_i && (wr_addr_i == A_CTL1);
  assign clr       = wr_tmr & wr_data_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q  <= '1;
      stop_q <= 1'b0;
    end else begin
      if (wr_mod) mod_q  <= wr_data_i;
      if (wr_tmr) stop_q <= wr_data_i[0];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_regs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q[c] <= '0;
        ctl_q[c] <= '0;
      end else begin
        if (wr_cmp[c]) cmp_q[c] <= wr_data_i;
        if (wr_ctl[c]) ctl_q[c] <= ch_ctl_t'(wr_data_i[CTL_W-1:0]);
      end
    end
  end

  logic [CNT_W-1:0] cnt_nxt;
  logic             adv, wrap;

  bpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .stop_i    (stop_q),
    .clr_i     (clr),
    .mod_i     (mod_q),
    .cnt_o     (cnt_o),
    .cnt_nxt_o (cnt_nxt),
    .adv_o     (adv),
    .wrap_o    (wrap)
  );

  logic buf_en, act_nxt;
  assign buf_en = (ctl_q[0].mode == MODE_BUF);

  bpwm_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .buf_en_i  (buf_en),
    .wrap_i    (wrap),
    .wr_cmp0_i (wr_cmp[0]),
    .wr_cmp1_i (wr_cmp[1]),
    .act_nxt_o (act_nxt)
  );

  logic [CNT_W-1:0] ch_cmp [N_CH];
  logic [N_CH-1:0]  out_raw;

  assign ch_cmp[0] = (buf_en && act_nxt) ? cmp_q[1] : cmp_q[0];
  assign ch_cmp[1] = cmp_q[1];

  for (genvar c = 0; c < N_CH; c++) begin : g_out
    bpwm_out #(.CNT_W(CNT_W)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (adv),
      .wrap_i    (wrap),
      .cnt_nxt_i (cnt_nxt),
      .cmp_i     (ch_cmp[c]),
      .ctl_i     (ctl_q[c]),
      .out_o     (out_raw[c])
    );
  end

  assign ch0_pwm_o  = out_raw[0] & ((ctl_q[0].mode == MODE_UNBUF) | buf_en);
  assign ch1_pwm_o  = out_raw[1] & ~buf_en & (ctl_q[1].mode == MODE_UNBUF);
  assign ch1_free_o = buf_en;

  p_ch1_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en && $past(buf_en)) |-> (!ch1_pwm_o && ch1_free_o));
endmodule

// File: tb/bpwm_pair_tb.sv
module bpwm_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 8;
  // {modulo, compare, set_on_match, expected high count per period}
  localparam int VEC [NV][4] = '{
    '{9, 3, 0, 3}, '{9, 0, 0, 0}, '{9, 12, 0, 10}, '{9, 3, 1, 7},
    '{4, 4, 0, 4}, '{15, 15, 1, 1}, '{15, 0, 1, 16}, '{7, 9, 1, 0}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt;
  logic ch0, ch1, free1;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpwm_pair #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .cnt_o(cnt),
    .ch0_pwm_o(ch0), .ch1_pwm_o(ch1), .ch1_free_o(free1)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1; wr_addr = a; wr_data = W'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_cnt(input int k);
    do @(negedge clk); while (cnt != W'(k));
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += (ch == 0) ? int'(ch0) : int'(ch1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi, c0, o0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset cnt", int'(cnt), 0);
    chk("R1 reset ch0", int'(ch0), 0);
    chk("R1 reset ch1", int'(ch1), 0);
    chk("R1 reset free", int'(free1), 0);
    tick = 1;

    // R1 / R3 counting and wrap after clear
    wr(3'd0, 5);
    wr(3'd5, 2);
    chk("R3 cleared", int'(cnt), 0);
    for (int i = 1; i < 9; i++) begin
      @(negedge clk);
      chk("R1 count seq", int'(cnt), i % 6);
    end

    // R2 stop bit and idle tick
    wr(3'd5, 1);
    c0 = int'(cnt);
    repeat (8) @(negedge clk);
    chk("R2 stop holds", int'(cnt), c0);
    wr(3'd5, 0);
    tick = 0;
    c0 = int'(cnt);
    repeat (8) @(negedge clk);
    chk("R2 tick low holds", int'(cnt), c0);
    tick = 1;

    // R5 R6 R7 duty-cycle table
    for (int v = 0; v < NV; v++) begin
      wr(3'd5, 3);
      wr(3'd0, VEC[v][0]);
      wr(3'd1, VEC[v][1]);
      wr(3'd3, VEC[v][2] ? 'h1D : 'h19);
      wr(3'd5, 0);
      repeat (3 * (VEC[v][0] + 1) + 2) @(negedge clk);
      count_high(0, VEC[v][0] + 1, hi);
      chk($sformatf("R6 R7 duty vec %0d", v), hi, VEC[v][3]);
    end

    // R5 no-action edge field holds level (force high first)
    wr(3'd0, 9); wr(3'd1, 12); wr(3'd3, 'h19);
    repeat (25) @(negedge clk);
    wr(3'd3, 'h05);
    count_high(0, 20, hi);
    chk("R5 no action holds", hi, 20);

    // R4 mode 00 forces low, channel 1 unbuffered works
    wr(3'd3, 'h18);
    count_high(0, 10, hi);
    chk("R4 mode off low", hi, 0);
    wr(3'd2, 3); wr(3'd4, 'h19);
    repeat (25) @(negedge clk);
    count_high(1, 10, hi);
    chk("R4 ch1 unbuffered", hi, 3);

    // R8 buffered entry: compare 0 active
    wr(3'd5, 3);
    wr(3'd1, 3); wr(3'd2, 8); wr(3'd3, 'h1A);
    wr(3'd5, 0);
    repeat (25) @(negedge clk);
    count_high(0, 10, hi);
    chk("R8 cmp0 first", hi, 3);
    // R12 pin released, control 1 ignored
    chk("R12 free flag", int'(free1), 1);
    wr(3'd4, 'h1D);
    count_high(1, 20, hi);
    chk("R12 ch1 low", hi, 0);
    count_high(0, 10, hi);
    chk("R12 ch0 unaffected", hi, 3);

    // R9 inactive write deferred to next wrap
    wait_cnt(1);
    wr(3'd2, 7);
    wait_cnt(5);
    chk("R9 old width this period", int'(ch0), 0);
    wait_cnt(0);
    wait_cnt(5);
    chk("R9 new width next period", int'(ch0), 1);
    count_high(0, 10, hi);
    chk("R9 width", hi, 7);

    // R11 active write immediate
    wait_cnt(1);
    wr(3'd2, 4);
    wait_cnt(5);
    chk("R11 immediate", int'(ch0), 0);
    count_high(0, 10, hi);
    chk("R11 width", hi, 4);

    // R10 most recent write wins
    wr(3'd5, 1);
    wr(3'd1, 2);
    wr(3'd2, 6);
    wr(3'd5, 0);
    repeat (25) @(negedge clk);
    count_high(0, 10, hi);
    chk("R10 last write active", hi, 6);
    wr(3'd1, 2);
    repeat (25) @(negedge clk);
    count_high(0, 10, hi);
    chk("R10 swap to cmp0", hi, 2);

    // R2 output frozen while stopped
    wr(3'd5, 1);
    o0 = int'(ch0);
    count_high(0, 10, hi);
    chk("R2 output frozen", hi, o0 * 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule